// File: doc/BRIEF.md
# Auxiliary Memory Switch and Page Bank Mapper

This block keeps the small set of single-bit memory-configuration switches of an 8-bit home-computer memory controller and converts them, together with three language-card control bits supplied from outside, into a bank choice for any 256-byte page of the 64 KiB address space. The read side and the write side of a page each get their own 3-bit bank code. This lets a page be read from one memory while writes go to another.

The CPU changes a switch by writing to one of a pair of I/O addresses. The odd address of the pair turns the switch on and the even address turns it off; the data byte is not used. Switch states are read back at a separate group of status addresses, in data bit 7. The bank lookup is combinational: the caller presents a page number on `pg_addr` and gets `rd_bank` and `wr_bank` back in the same cycle. After each switch write, `map_changed` pulses for one cycle, so that a downstream page table can reload.

Top module: `mem_page_mapper`

## Requirements
- R1: A write with `bus_addr` in 0xC000–0xC00B loads switch number `bus_addr[3:1]` with `bus_addr[0]` at the clock edge. The switches are numbered 0 display-store, 1 aux-read, 2 aux-write, 3 internal-slot-ROM, 4 alt-zero-page and 5 slot-3-ROM.
- R2: Switch states are unchanged by writes outside 0xC000–0xC00B and by reads of any address.
- R3: A read at 0xC013–0xC017 returns switches 1–5 in that order, and a read at 0xC018 returns switch 0. In each case `rd_hit` is 1 and `rd_data` is 0x80 when the switch is on and 0x00 when it is off. Any other access gives `rd_hit`=0 and `rd_data`=0x00.
- R4: While reset is asserted, and after it is released, all switches read 0 and `map_changed` is 0.
- R5: `map_changed` is 1 for exactly the one cycle after each clock edge that loaded a switch, and 0 at all other times.
- R6: The bank codes are 0 main RAM, 1 aux RAM, 2 ROM, 3 card ROM, 4 switched RAM, 5 switched RAM second bank, 6 aux switched RAM and 7 aux switched RAM second bank. For pages 0x00–0xBF, `rd_bank` is 1 when aux-read is on and 0 otherwise, and `wr_bank` follows aux-write in the same way.
- R7: Pages 0xC1–0xC7 give code 3 on both sides. Page 0xC3 instead gives 2 unless slot-3-ROM is on. Pages 0xC0 and 0xC8–0xCF give 2 on both sides.
- R8: For pages 0xD0–0xFF, `rd_bank` is switched RAM when `lc_rd_en` is 1 and 2 (ROM) otherwise. `wr_bank` follows `lc_wr_en` in the same way.
- R9: When alt-zero-page is on, the switched RAM for pages 0xD0–0xFF is the aux one (code 6 or 7) instead of the main one (code 4 or 5).
- R10: For pages 0xD0–0xDF only, the switched RAM code is incremented by one when `lc_bank2` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| lc_rd_en | input | 1 | Language-card read enable |
| lc_wr_en | input | 1 | Language-card write enable |
| lc_bank2 | input | 1 | Language-card second-bank select |
| pg_addr | input | 8 | Page number to look up |
| rd_bank | output | 3 | Bank code for reads of `pg_addr` |
| wr_bank | output | 3 | Bank code for writes of `pg_addr` |
| rd_hit | output | 1 | Status address decoded on a read |
| rd_data | output | 8 | Status read data |
| map_changed | output | 1 | One-cycle pulse after a switch update |

## Verification
Each switch is set alone through its odd address and read back at every status address, so that a mix-up in switch numbering or status order shows up as a wrong bit. After each switch change, the bank lookup sweeps the page boundaries 0xBF/0xC0, 0xC2/0xC3/0xC4, 0xC7/0xC8, 0xCF/0xD0 and 0xDF/0xE0. This is done for all eight language-card input combinations, with alt-zero-page both on and off, which separates the low-RAM, slot, ROM, second-bank and aux selections. Writes next to the switch range (0xC00C–0xC010, 0xC101) and reads of the switch addresses are then applied, and the status is read back to show that nothing moved.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 8;
  localparam int BANK_W = 3;
  localparam int NUM_SW = 6;
  localparam int SW_IDX_W = $clog2(NUM_SW);

  // switch positions in the switch vector (order set by the write address pairs)
  localparam int SW_DSTORE = 0;
  localparam int SW_AUXRD  = 1;
  localparam int SW_AUXWR  = 2;
  localparam int SW_INTSLT = 3;
  localparam int SW_ALTZP  = 4;
  localparam int SW_SLOT3  = 5;

  typedef enum logic [BANK_W-1:0] {
    BK_MAIN   = 3'd0,
    BK_AUX    = 3'd1,
    BK_ROM    = 3'd2,
    BK_CARD   = 3'd3,
    BK_LC     = 3'd4,
    BK_LC2    = 3'd5,
    BK_AUXLC  = 3'd6,
    BK_AUXLC2 = 3'd7
  } bank_e;
endpackage

// File: rtl/mpm_switch_regs.sv
module mpm_switch_regs
  import mpm_pkg::*;
#(
  parameter int          N_SW    = NUM_SW,
  parameter logic [15:0] WR_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic [N_SW-1:0]   sw_q,
  output logic              chg_q
);
  localparam int IDX_W = $clog2(N_SW);

  logic [IDX_W-1:0] idx;
  logic             wr_hit;
  logic [N_SW-1:0]  sw_d;
  logic [N_SW-1:0]  sw_en;

  always_comb begin
    idx    = bus_addr[IDX_W:1];
    wr_hit = bus_wr && (bus_addr[ADDR_W-1:IDX_W+1] == WR_BASE[ADDR_W-1:IDX_W+1])
             && ({1'b0, idx} < (IDX_W+1)'(N_SW));
  end

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    always_comb begin
      sw_en[i] = wr_hit && (idx == IDX_W'(i));
      sw_d[i]  = bus_addr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_q[i] <= 1'b0;
      end else if (sw_en[i]) begin
        sw_q[i] <= sw_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= wr_hit;
    end
  end
endmodule

// File: rtl/mpm_status.sv
module mpm_status
  import mpm_pkg::*;
#(
  parameter logic [7:0] IO_PAGE = 8'hC0,
  parameter logic [7:0] STAT_LO = 8'h13,
  parameter logic [7:0] STAT_HI = 8'h18
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic [NUM_SW-1:0] sw_q,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0]          lo;
  logic [7:0]          offs;
  logic [SW_IDX_W-1:0] idx;

  always_comb begin
    lo     = bus_addr[7:0];
    rd_hit = bus_rd && (bus_addr[ADDR_W-1:8] == IO_PAGE) && (lo >= STAT_LO) && (lo <= STAT_HI);
    // the last status address wraps back to switch 0
    offs   = lo - (STAT_LO - 8'd1);
    idx    = (lo == STAT_HI) ? '0 : offs[SW_IDX_W-1:0];
    rd_data = '0;
    if (rd_hit) begin
      rd_data[DATA_W-1] = sw_q[idx];
    end
  end
endmodule

// File: rtl/mpm_page_decode.sv
module mpm_page_decode
  import mpm_pkg::*;
(
  input  logic [PAGE_W-1:0] pg_addr,
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic              alt_zp,
  input  logic              slot3,
  input  logic              lc_rd_en,
  input  logic              lc_wr_en,
  input  logic              lc_bank2,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank
);
  logic [BANK_W-1:0] lc_code;
  logic              in_low, in_slot, in_lc, in_lc_lo;

  always_comb begin
    in_low   = pg_addr < 8'hC0;
    in_slot  = (pg_addr >= 8'hC1) && (pg_addr <= 8'hC7);
    in_lc    = pg_addr >= 8'hD0;
    in_lc_lo = in_lc && (pg_addr <= 8'hDF);
    lc_code  = alt_zp ? BK_AUXLC : BK_LC;
    if (in_lc_lo && lc_bank2) begin
      lc_code = lc_code + 3'd1;
    end

    rd_bank = BK_ROM;
    wr_bank = BK_ROM;
    if (in_low) begin
      rd_bank = aux_rd ? BK_AUX : BK_MAIN;
      wr_bank = aux_wr ? BK_AUX : BK_MAIN;
    end else if (in_slot) begin
      if ((pg_addr != 8'hC3) || slot3) begin
        rd_bank = BK_CARD;
        wr_bank = BK_CARD;
      end
    end else if (in_lc) begin
      if (lc_rd_en) rd_bank = lc_code;
      if (lc_wr_en) wr_bank = lc_code;
    end
  end
endmodule

// File: rtl/mem_page_mapper.sv
module mem_page_mapper
  import mpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              lc_rd_en,
  input  logic              lc_wr_en,
  input  logic              lc_bank2,
  input  logic [PAGE_W-1:0] pg_addr,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              map_changed
);
  logic              rst_meta_q;
  logic              rst_sync_n;
  logic [NUM_SW-1:0] sw_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mpm_switch_regs #(.N_SW(NUM_SW), .WR_BASE(16'hC000)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .sw_q     (sw_q),
    .chg_q    (map_changed)
  );

  mpm_status u_stat (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .sw_q     (sw_q),
    .rd_hit   (rd_hit),
    .rd_data  (rd_data)
  );

  mpm_page_decode u_dec (
    .pg_addr  (pg_addr),
    .aux_rd   (sw_q[SW_AUXRD]),
    .aux_wr   (sw_q[SW_AUXWR]),
    .alt_zp   (sw_q[SW_ALTZP]),
    .slot3    (sw_q[SW_SLOT3]),
    .lc_rd_en (lc_rd_en),
    .lc_wr_en (lc_wr_en),
    .lc_bank2 (lc_bank2),
    .rd_bank  (rd_bank),
    .wr_bank  (wr_bank)
  );
endmodule

// File: rtl/mem_page_mapper_chk.sv
module mem_page_mapper_chk
  import mpm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              lc_rd_en,
  input logic [PAGE_W-1:0] pg_addr,
  input logic [NUM_SW-1:0] sw_q,
  input logic [BANK_W-1:0] rd_bank,
  input logic [BANK_W-1:0] wr_bank,
  input logic              rd_hit,
  input logic [DATA_W-1:0] rd_data,
  input logic              map_changed
);
  logic       wr_sel;
  logic [2:0] wr_idx;

  always_comb begin
    wr_idx = bus_addr[3:1];
    wr_sel = bus_wr && (bus_addr[15:4] == 12'hC00) && (wr_idx < 3'd6);
  end

  // R1
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (sw_q[$past(wr_idx)] == $past(bus_addr[0])));

  // R2
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sw_q));

  // R5
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> map_changed);

  // R5
  chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> !map_changed);

  // R3
  stat_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (bus_rd && (rd_data[6:0] == 7'd0)));

  // R3
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 8'd0));

  // R7
  slot3_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pg_addr == 8'hC3) && !sw_q[SW_SLOT3]) |-> ((rd_bank == BK_ROM) && (wr_bank == BK_ROM)));

  // R8
  lc_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pg_addr >= 8'hD0) && !lc_rd_en) |-> (rd_bank == BK_ROM));
endmodule

bind mem_page_mapper mem_page_mapper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .lc_rd_en    (lc_rd_en),
  .pg_addr     (pg_addr),
  .sw_q        (sw_q),
  .rd_bank     (rd_bank),
  .wr_bank     (wr_bank),
  .rd_hit      (rd_hit),
  .rd_data     (rd_data),
  .map_changed (map_changed)
);

// File: tb/mem_page_mapper_bench.sv
module mem_page_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        lc_rd_en = 1'b0;
  logic        lc_wr_en = 1'b0;
  logic        lc_bank2 = 1'b0;
  logic [7:0]  pg_addr = 8'h00;
  logic [2:0]  rd_bank, wr_bank;
  logic        rd_hit;
  logic [7:0]  rd_data;
  logic        map_changed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  bit ref_sw [6];
  bit ref_chg = 0;

  always #4 clk = ~clk;

  mem_page_mapper u_mem_page_mapper (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .lc_rd_en(lc_rd_en), .lc_wr_en(lc_wr_en), .lc_bank2(lc_bank2), .pg_addr(pg_addr),
    .rd_bank(rd_bank), .wr_bank(wr_bank), .rd_hit(rd_hit), .rd_data(rd_data),
    .map_changed(map_changed)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      finish_run();
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_bank(input int pg, input bit is_wr);
    int base;
    bit en;
    if (pg < 'hC0) return ((is_wr ? ref_sw[2] : ref_sw[1]) ? 1 : 0);
    if (pg >= 'hC1 && pg <= 'hC7) return ((pg == 'hC3 && !ref_sw[5]) ? 2 : 3);
    if (pg < 'hD0) return 2;
    en = is_wr ? lc_wr_en : lc_rd_en;
    if (!en) return 2;
    base = ref_sw[4] ? 6 : 4;
    if (pg <= 'hDF && lc_bank2) base = base + 1;
    return base;
  endfunction

  function automatic string bank_tag(input int pg);
    if (pg < 'hC0) return "R6";
    if (pg < 'hD0) return "R7";
    if (ref_sw[4]) return "R9";
    if (pg <= 'hDF && lc_bank2) return "R10";
    return "R8";
  endfunction

  function automatic int page_at(input int k);
    case (k)
      0: return 'h00;  1: return 'h7F;  2: return 'hBF;  3: return 'hC0;
      4: return 'hC1;  5: return 'hC2;  6: return 'hC3;  7: return 'hC4;
      8: return 'hC7;  9: return 'hC8;  10: return 'hCF; 11: return 'hD0;
      12: return 'hDF; 13: return 'hE0; default: return 'hFF;
    endcase
  endfunction

  function automatic logic [15:0] stat_addr(input int i);
    return (i == 0) ? 16'hC018 : 16'(16'hC012 + i);
  endfunction

  // one bus cycle: drive at falling edge, compare, then advance the model at the rising edge
  task automatic step(input logic [15:0] a, input bit rd, input bit wr, input int pg, input string stag);
    int exp_d;
    bit exp_h;
    int idx;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; pg_addr = 8'(pg);
    #1;
    exp_h = rd && a >= 16'hC013 && a <= 16'hC018;
    idx = (a == 16'hC018) ? 0 : int'(a) - 'hC012;
    exp_d = (exp_h && ref_sw[idx]) ? 'h80 : 0;
    check(stag, "rd_hit", rd_hit, exp_h);
    check(stag, "rd_data", rd_data, exp_d);
    check("R5", "map_changed", map_changed, ref_chg);
    check(bank_tag(pg), "rd_bank", rd_bank, exp_bank(pg, 0));
    check(bank_tag(pg), "wr_bank", wr_bank, exp_bank(pg, 1));
    @(posedge clk);
    ref_chg = wr && a >= 16'hC000 && a <= 16'hC00B;
    if (ref_chg) ref_sw[a[3:1]] = a[0];
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 6; i++) step(stat_addr(i), 1, 0, 'h00, tag);
  endtask

  task automatic sweep();
    for (int lc = 0; lc < 8; lc++) begin
      lc_rd_en = lc[0]; lc_wr_en = lc[1]; lc_bank2 = lc[2];
      for (int k = 0; k < 15; k++) step(16'h0400, 0, 0, page_at(k), "R3");
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) ref_sw[i] = 0;
    // R4: outputs while reset is held
    repeat (2) @(negedge clk);
    bus_addr = 16'hC013; bus_rd = 1'b1; #1;
    check("R4", "rd_data in reset", rd_data, 0);
    check("R4", "map_changed in reset", map_changed, 0);
    bus_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    read_all("R4");
    sweep();
    // R1: each switch turned on alone, then off
    for (int i = 0; i < 6; i++) begin
      step(16'(16'hC001 + 2 * i), 0, 1, 'hC3, "R1");
      read_all("R1");
      sweep();
      step(16'(16'hC000 + 2 * i), 0, 1, 'hD0, "R1");
      read_all("R1");
    end
    // two writes back to back
    step(16'hC009, 0, 1, 'hDF, "R1");
    step(16'hC00B, 0, 1, 'hC3, "R1");
    step(16'hC003, 0, 1, 'h10, "R1");
    read_all("R1");
    sweep();
    // R2: writes beside the switch range and reads of switch addresses
    step(16'hC00C, 0, 1, 'h00, "R2");
    step(16'hC00D, 0, 1, 'h00, "R2");
    step(16'hC00F, 0, 1, 'h00, "R2");
    step(16'hC010, 0, 1, 'h00, "R2");
    step(16'hC101, 0, 1, 'h00, "R2");
    step(16'hC008, 1, 0, 'h00, "R2");
    step(16'hC005, 1, 0, 'h00, "R2");
    step(16'hC013, 0, 0, 'h00, "R2");
    read_all("R2");
    // R3: neighbours of the status window
    step(16'hC012, 1, 0, 'h00, "R3");
    step(16'hC019, 1, 0, 'h00, "R3");
    step(16'hD013, 1, 0, 'h00, "R3");
    step(16'hC005, 0, 1, 'hE0, "R1");
    step(16'hC001, 0, 1, 'hE0, "R1");
    read_all("R3");
    sweep();
    done = 1;
    finish_run();
  end
endmodule